// File: doc/BRIEF.md
# Parallel Programming Command Front-End

This block is the device-side entry point of a parallel flash-programming port. An external programmer presents a 16-bit word together with a 4-bit mode selector and raises a strobe. The block samples the strobe into its own clock domain. On a rising strobe edge it latches the word into the register the mode selects: command, address low half, address high half or write data. A command word is decoded into a one-cycle, one-hot operation request for the back end that drives the flash array. A code that matches no operation sets a sticky error flag instead.

A ready output paces the programmer. After reset the block waits a fixed power-on delay. It then counts edges of the external clock input over a window of internal cycles. If enough edges arrive, it selects the external clock; otherwise it stays on the internal oscillator. Ready is raised only after this decision is final, and the decision does not change afterwards. After each latched word, ready drops: for a single cycle after an address or data word or an unknown command, and until the back end signals completion after a valid command.

Top module: `par_prog_frontend`

## Requirements
- R1: Out of reset, ready_o, op_req_o and cmd_err_o are all 0. ready_o stays 0 for at least POR_CYCLES + DET_WINDOW cycles and then rises to 1.
- R2: Over a window of DET_WINDOW cycles following the power-on delay, the block counts rising edges of ext_clk_i. use_ext_clk_o becomes 1 if at least EXT_THRESH edges were counted and stays 0 otherwise. Its value does not change after ready_o first rises.
- R3: A word latched with mode_i = 4'b0000 is decoded to a one-hot op_req_o bit. The codes map to bits as follows: 0x0011→0, 0x0012→1, 0x0013→2, 0x0014→3, 0x0015→4, 0x001E→5, 0x001F→6, 0x0022→7, 0x0024→8, 0x0025→9, 0x0032→10, 0x0034→11, 0x0035→12, 0x0042→13, 0x0044→14, 0x0054→15. All 16 bits of the word are compared.
- R4: op_req_o is high for exactly one cycle per valid command. ready_o stays 0 from the capture until the cycle after op_done_i is seen high.
- R5: A command word matching no code in R3 raises no request. It sets cmd_err_o, which stays 1 until reset, and ready_o returns to 1 one cycle after the capture cycle.
- R6: mode_i = 4'b0001 latches the word into addr_o[15:0], and mode_i = 4'b0010 latches it into addr_o[31:16]. The other half is not disturbed.
- R7: mode_i = 4'b0101 latches the word into wdata_o.
- R8: Any other mode_i value writes no register, raises no request and leaves ready_o at 1.
- R9: A word is latched only on a rising edge of strobe_i. A strobe held high across the return of ready_o does not cause a second capture.
- R10: Strobe edges that occur while ready_o is 0 are ignored. This includes edges during the power-on delay and edges while waiting for op_done_i.
- R11: After an address or data capture, ready_o is 0 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External clock candidate, sampled for detection |
| strobe_i | input | 1 | Programmer strobe, asynchronous |
| mode_i | input | 4 | Target register selector |
| data_i | input | 16 | Strobed data word |
| op_done_i | input | 1 | Back end finished the requested operation |
| ready_o | output | 1 | Block accepts the next strobe |
| use_ext_clk_o | output | 1 | Clock source decision: 1 selects the external clock |
| addr_o | output | 32 | Address register |
| wdata_o | output | 16 | Data register |
| op_req_o | output | 16 | One-hot, one-cycle operation request |
| cmd_err_o | output | 1 | Sticky unknown-command flag |

## Verification
The bench uses a power-on delay of 20 cycles, a 32-cycle detection window and a threshold of 4 edges. With these values the whole start-up sequence finishes within about 55 cycles, and both clock-source outcomes are reachable in one run. A second instance is fed with an external clock of one edge per 40 cycles, which stays below the threshold, while the main instance sees one edge per 4 cycles. The small window also keeps the ready-low boundary close enough to check the exact cycle around it.

// File: rtl/ppf_pkg.sv
package ppf_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned MODE_W  = 4;
  localparam int unsigned NUM_OPS = 16;

  localparam logic [MODE_W-1:0] MODE_CMD    = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_ADR_LO = 4'b0001;
  localparam logic [MODE_W-1:0] MODE_ADR_HI = 4'b0010;
  localparam logic [MODE_W-1:0] MODE_DATA   = 4'b0101;

  // Request bit indices, ordered by code value
  localparam int unsigned OP_READ      = 0;
  localparam int unsigned OP_WR_PG     = 1;
  localparam int unsigned OP_ERASE_ALL = 2;
  localparam int unsigned OP_LOCK_SET  = 3;
  localparam int unsigned OP_LOCK_GET  = 4;
  localparam int unsigned OP_VERSION   = 5;
  localparam int unsigned OP_WR_MEM    = 6;
  localparam int unsigned OP_WR_PG_LK  = 7;
  localparam int unsigned OP_LOCK_CLR  = 8;
  localparam int unsigned OP_GPB_GET   = 9;
  localparam int unsigned OP_ER_WR     = 10;
  localparam int unsigned OP_GPB_SET   = 11;
  localparam int unsigned OP_SEC_GET   = 12;
  localparam int unsigned OP_ER_WR_LK  = 13;
  localparam int unsigned OP_GPB_CLR   = 14;
  localparam int unsigned OP_SEC_SET   = 15;

  typedef enum logic [2:0] {
    ST_POR,
    ST_DET,
    ST_READY,
    ST_HOLD,
    ST_BUSY
  } fe_state_e;
endpackage

// File: rtl/ppf_strobe_sync.sv
module ppf_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_i};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~last_q;

  assert_single_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ppf_clk_detect.sv
module ppf_clk_detect #(
  parameter int unsigned WINDOW = 64,
  parameter int unsigned THRESH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  input  logic start_i,
  output logic done_o,
  output logic ext_sel_o
);
  localparam int unsigned WIN_W = $clog2(WINDOW + 1);
  localparam int unsigned CNT_W = $clog2(THRESH + 1);

  logic             ext_edge;
  logic             active_q;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_full;

  ppf_strobe_sync #(.STAGES(2)) u_ext_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ext_clk_i),
    .rise_o (ext_edge)
  );

  assign cnt_full = (cnt_q >= CNT_W'(THRESH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      win_q     <= '0;
      cnt_q     <= '0;
      done_o    <= 1'b0;
      ext_sel_o <= 1'b0;
    end else if (active_q) begin
      win_q <= win_q + 1'b1;
      if (ext_edge && !cnt_full) cnt_q <= cnt_q + 1'b1;
      if (win_q == WIN_W'(WINDOW - 1)) begin
        active_q  <= 1'b0;
        done_o    <= 1'b1;
        ext_sel_o <= cnt_full || (ext_edge && cnt_q == CNT_W'(THRESH - 1));
      end
    end else if (start_i && !done_o) begin
      active_q <= 1'b1;
      win_q    <= '0;
      cnt_q    <= '0;
    end
  end

  assert_decision_final_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && $stable(ext_sel_o));
  assert_no_count_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |=> $stable(cnt_q) || active_q);
endmodule

// File: rtl/ppf_cmd_decode.sv
module ppf_cmd_decode
  import ppf_pkg::*;
(
  input  logic [WORD_W-1:0]  code_i,
  output logic [NUM_OPS-1:0] op_o,
  output logic               valid_o
);
  always_comb begin
    op_o = '0;
    unique case (code_i)
      16'h0011: op_o[OP_READ]      = 1'b1;
      16'h0012: op_o[OP_WR_PG]     = 1'b1;
      16'h0013: op_o[OP_ERASE_ALL] = 1'b1;
      16'h0014: op_o[OP_LOCK_SET]  = 1'b1;
      16'h0015: op_o[OP_LOCK_GET]  = 1'b1;
      16'h001E: op_o[OP_VERSION]   = 1'b1;
      16'h001F: op_o[OP_WR_MEM]    = 1'b1;
      16'h0022: op_o[OP_WR_PG_LK]  = 1'b1;
      16'h0024: op_o[OP_LOCK_CLR]  = 1'b1;
      16'h0025: op_o[OP_GPB_GET]   = 1'b1;
      16'h0032: op_o[OP_ER_WR]     = 1'b1;
      16'h0034: op_o[OP_GPB_SET]   = 1'b1;
      16'h0035: op_o[OP_SEC_GET]   = 1'b1;
      16'h0042: op_o[OP_ER_WR_LK]  = 1'b1;
      16'h0044: op_o[OP_GPB_CLR]   = 1'b1;
      16'h0054: op_o[OP_SEC_SET]   = 1'b1;
      default:  op_o = '0;
    endcase
  end

  assign valid_o = |op_o;

  always_comb begin
    assert_decode_onehot_R3: assert ($onehot0(op_o));
  end
endmodule

// File: rtl/par_prog_frontend.sv
module par_prog_frontend
  import ppf_pkg::*;
#(
  parameter int unsigned POR_CYCLES = 1024,
  parameter int unsigned DET_WINDOW = 256,
  parameter int unsigned EXT_THRESH = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ext_clk_i,
  input  logic                 strobe_i,
  input  logic [MODE_W-1:0]    mode_i,
  input  logic [WORD_W-1:0]    data_i,
  input  logic                 op_done_i,
  output logic                 ready_o,
  output logic                 use_ext_clk_o,
  output logic [2*WORD_W-1:0]  addr_o,
  output logic [WORD_W-1:0]    wdata_o,
  output logic [NUM_OPS-1:0]   op_req_o,
  output logic                 cmd_err_o
);
  localparam int unsigned POR_W = $clog2(POR_CYCLES + 1);

  fe_state_e          state_q;
  logic [POR_W-1:0]   por_q;
  logic               stb_rise;
  logic               det_done;
  logic [NUM_OPS-1:0] dec_op;
  logic               dec_valid;
  logic               capture;

  ppf_strobe_sync #(.STAGES(2)) u_stb_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(strobe_i),
    .rise_o (stb_rise)
  );

  ppf_clk_detect #(.WINDOW(DET_WINDOW), .THRESH(EXT_THRESH)) u_clk_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_clk_i(ext_clk_i),
    .start_i  (state_q == ST_DET),
    .done_o   (det_done),
    .ext_sel_o(use_ext_clk_o)
  );

  ppf_cmd_decode u_dec (
    .code_i (data_i),
    .op_o   (dec_op),
    .valid_o(dec_valid)
  );

  assign capture = (state_q == ST_READY) && stb_rise;
  assign ready_o = (state_q == ST_READY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_POR;
      por_q     <= '0;
      addr_o    <= '0;
      wdata_o   <= '0;
      op_req_o  <= '0;
      cmd_err_o <= 1'b0;
    end else begin
      op_req_o <= '0;
      unique case (state_q)
        ST_POR: begin
          por_q <= por_q + 1'b1;
          if (por_q == POR_W'(POR_CYCLES - 1)) state_q <= ST_DET;
        end
        ST_DET: if (det_done) state_q <= ST_READY;
        ST_READY: if (capture) begin
          unique case (mode_i)
            MODE_CMD: begin
              if (dec_valid) begin
                op_req_o <= dec_op;
                state_q  <= ST_BUSY;
              end else begin
                cmd_err_o <= 1'b1;
                state_q   <= ST_HOLD;
              end
            end
            MODE_ADR_LO: begin
              addr_o[WORD_W-1:0] <= data_i;
              state_q            <= ST_HOLD;
            end
            MODE_ADR_HI: begin
              addr_o[2*WORD_W-1:WORD_W] <= data_i;
              state_q                   <= ST_HOLD;
            end
            MODE_DATA: begin
              wdata_o <= data_i;
              state_q <= ST_HOLD;
            end
            default: ;
          endcase
        end
        ST_HOLD: state_q <= ST_READY;
        ST_BUSY: if (op_done_i) state_q <= ST_READY;
        default: state_q <= ST_POR;
      endcase
    end
  end

  assert_req_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(op_req_o));
  assert_req_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_req_o != '0) |=> (op_req_o == '0));
  assert_req_not_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_req_o != '0) |-> !ready_o);
  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |=> cmd_err_o);
  assert_err_from_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_err_o) |-> $past(ready_o));
  assert_wdata_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wdata_o) |-> $past(ready_o));
  assert_addr_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(addr_o) |-> $past(ready_o));
  assert_clk_fixed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> $stable(use_ext_clk_o));
  assert_ready_after_det_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> det_done);
endmodule

// File: tb/par_prog_frontend_test.sv
module par_prog_frontend_test;
  localparam int POR = 20;
  localparam int WIN = 32;
  localparam int THR = 4;
  localparam int NV  = 20;

  localparam logic [15:0] CODES [NV] = '{
    16'h0011, 16'h0012, 16'h0016, 16'h0013, 16'h0014, 16'h0015, 16'h001E,
    16'h001F, 16'h0022, 16'h0024, 16'h0025, 16'h0032, 16'h0034, 16'h0035,
    16'h0042, 16'h0044, 16'h0054, 16'h0000, 16'h1011, 16'hFFFF};
  localparam int BITS [NV] = '{
    0, 1, -1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15, -1, -1, -1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_fast = 1'b0, ext_slow = 1'b0;
  logic strobe = 1'b0, done = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] data = '0;
  logic        ready, use_ext, err, ready_s, use_ext_s, err_s;
  logic [31:0] addr, addr_s;
  logic [15:0] wdata, wdata_s, req, req_s;

  int errors = 0, checks = 0;
  bit seen_inv = 0;
  logic [15:0] s_req;
  logic        s_ready, s_err;

  always #10 clk = ~clk;
  always #40 ext_fast = ~ext_fast;
  always #400 ext_slow = ~ext_slow;

  par_prog_frontend #(.POR_CYCLES(POR), .DET_WINDOW(WIN), .EXT_THRESH(THR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_fast), .strobe_i(strobe),
    .mode_i(mode), .data_i(data), .op_done_i(done), .ready_o(ready),
    .use_ext_clk_o(use_ext), .addr_o(addr), .wdata_o(wdata), .op_req_o(req),
    .cmd_err_o(err));

  par_prog_frontend #(.POR_CYCLES(POR), .DET_WINDOW(WIN), .EXT_THRESH(THR)) uut_slow (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_slow), .strobe_i(1'b0),
    .mode_i(4'b0000), .data_i(16'h0000), .op_done_i(1'b0), .ready_o(ready_s),
    .use_ext_clk_o(use_ext_s), .addr_o(addr_s), .wdata_o(wdata_s), .op_req_o(req_s),
    .cmd_err_o(err_s));

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  // Raise strobe with mode/data, sample at the negedge after the capture edge
  task automatic pulse(input logic [3:0] m, input logic [15:0] d, input bit drop);
    repeat (3) @(negedge clk);
    mode = m; data = d; strobe = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    s_req = req; s_ready = ready; s_err = err;
    if (drop) strobe = 1'b0;
  endtask

  task automatic finish_op();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready === 1'b0, "R1 ready after reset", 32'(ready), 0);
    check(req === 16'h0, "R1 req after reset", 32'(req), 0);
    check(err === 1'b0, "R1 err after reset", 32'(err), 0);

    // R10: strobe during power-on delay
    mode = 4'b0101; data = 16'hDEAD; strobe = 1'b1;
    repeat (5) @(negedge clk);
    strobe = 1'b0;
    repeat (POR + WIN - 8) @(negedge clk);
    check(ready === 1'b0, "R1 ready held low", 32'(ready), 0);
    for (int k = 0; k < 20 && ready !== 1'b1; k++) @(negedge clk);
    check(ready === 1'b1, "R1 ready released", 32'(ready), 1);
    check(wdata === 16'h0, "R10 strobe during power-on ignored", 32'(wdata), 0);
    check(use_ext === 1'b1, "R2 fast external clock selected", 32'(use_ext), 1);
    for (int k = 0; k < 20 && ready_s !== 1'b1; k++) @(negedge clk);
    check(ready_s === 1'b1 && use_ext_s === 1'b0, "R2 slow clock stays internal",
          {30'd0, ready_s, use_ext_s}, 32'h2);

    // Command table walk (R3, R4, R5)
    for (int i = 0; i < NV; i++) begin
      pulse(4'b0000, CODES[i], 1'b1);
      if (BITS[i] >= 0) begin
        check(s_req === 16'(1 << BITS[i]), "R3 decode", 32'(s_req), 32'(1 << BITS[i]));
        check(s_ready === 1'b0, "R4 ready low after command", 32'(s_ready), 0);
        check(s_err === seen_inv, "R5 err flag", 32'(s_err), 32'(seen_inv));
        @(negedge clk);
        check(req === 16'h0, "R4 one-cycle request", 32'(req), 0);
        repeat (3) @(negedge clk);
        check(ready === 1'b0, "R4 waits for done", 32'(ready), 0);
        finish_op();
        check(ready === 1'b1, "R4 ready after done", 32'(ready), 1);
      end else begin
        seen_inv = 1;
        check(s_req === 16'h0, "R5 no request for unknown", 32'(s_req), 0);
        check(s_err === 1'b1 && s_ready === 1'b0, "R5 err set, ready low",
              {30'd0, s_err, s_ready}, 32'h2);
        @(negedge clk);
        check(ready === 1'b1, "R5 ready back next cycle", 32'(ready), 1);
      end
    end

    // R6, R11: address halves
    pulse(4'b0001, 16'h1234, 1'b1);
    check(s_ready === 1'b0, "R11 ready low after address", 32'(s_ready), 0);
    @(negedge clk);
    check(ready === 1'b1, "R11 ready back after one cycle", 32'(ready), 1);
    check(addr[15:0] === 16'h1234, "R6 address low", addr, 32'h1234);
    pulse(4'b0010, 16'hABCD, 1'b1);
    @(negedge clk);
    check(addr === 32'hABCD1234, "R6 address high keeps low", addr, 32'hABCD1234);

    // R7, R11: data
    pulse(4'b0101, 16'h5A5A, 1'b1);
    check(s_ready === 1'b0, "R11 ready low after data", 32'(s_ready), 0);
    @(negedge clk);
    check(wdata === 16'h5A5A && ready === 1'b1, "R7 data latched", 32'(wdata), 32'h5A5A);

    // R8: idle modes
    pulse(4'b0011, 16'hFFFF, 1'b1);
    check(s_ready === 1'b1 && s_req === 16'h0, "R8 idle keeps ready",
          {15'd0, s_ready, s_req}, 32'h10000);
    pulse(4'b1111, 16'h0011, 1'b1);
    @(negedge clk);
    check(addr === 32'hABCD1234 && wdata === 16'h5A5A && ready === 1'b1 && req === 16'h0,
          "R8 idle writes nothing", 32'(wdata), 32'h5A5A);

    // R9: held strobe
    pulse(4'b0101, 16'h1111, 1'b0);
    data = 16'h2222;
    repeat (6) @(negedge clk);
    check(wdata === 16'h1111, "R9 held strobe no recapture", 32'(wdata), 32'h1111);
    strobe = 1'b0;

    // R10: strobe while waiting for done
    pulse(4'b0000, 16'h0011, 1'b1);
    repeat (2) @(negedge clk);
    mode = 4'b0101; data = 16'h3333; strobe = 1'b1;
    repeat (5) @(negedge clk);
    strobe = 1'b0;
    repeat (3) @(negedge clk);
    finish_op();
    check(ready === 1'b1 && wdata === 16'h1111, "R10 busy strobe ignored",
          32'(wdata), 32'h1111);
    check(err === 1'b1, "R5 err still sticky", 32'(err), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule